// File: doc/BRIEF.md
# ECC Error Status and Capture Logger

This block sits beside a memory controller and records error events reported by its neighbours. The ECC decoder signals correctable and uncorrectable events. The address range checker signals accesses that fall outside the installed memory. The initialization sequencer signals that memory bring-up has finished. Each event arrives as a one-cycle pulse together with the address, the data word and the syndrome that belong to it.

Each error class has two sticky status bits, one for the first event and one for repeated events. Each class also has its own capture set, which freezes the address, and for ECC classes the data, of the first event in that class. The syndrome of the most recent ECC event stays readable. A level interrupt is raised while any enabled status bit is set. Software uses a simple word-addressed register port to read status, mask, syndrome and captures, and writes ones into the status word to acknowledge events.

Register map (word offsets, reads are combinational):

| Offset | Contents |
|--------|----------|
| 0 | Status: bits 6:0 are the status bits, bits 23:16 hold the syndrome. Writing 1 to any of bits 6:0 clears that status bit. |
| 1 | Interrupt mask, bits 6:0, read/write. |
| 2, 3 | Out-of-range capture: address low word, then address high word. |
| 4 to 7 | Correctable capture: address low word, address high word, data low word, data high word. |
| 8 to 11 | Uncorrectable capture: same four-word layout as the correctable capture. |

All other offsets read as zero.

Top module: `ecc_err_logger`

## Requirements
- R1: A pulse on `oor_evt_i` while status bit 0 is clear sets bit 0. A pulse while bit 0 is set also sets bit 1. The first event's `oor_addr_i` is readable at offsets 2 (low word) and 3 (high word).
- R2: A pulse on `ce_evt_i` sets status bit 2 if that bit is clear. It sets bit 3 if bit 2 was already set.
- R3: A pulse on `ue_evt_i` sets status bit 4 if that bit is clear. It sets bit 5 if bit 4 was already set.
- R4: A pulse on `init_done_i` sets status bit 6.
- R5: A class's capture registers load only in the cycle its first-event bit goes from 0 to 1. Later events of the class leave them unchanged. After an acknowledge, the next event captures again. The correctable set is at offsets 4 to 7: address low, address high, data low, data high.
- R6: Correctable and uncorrectable events use separate capture sets; the uncorrectable set is at offsets 8 to 11. An event in one class never changes the other class's set.
- R7: Status bits 23:16 hold the `ecc_syn_i` value of the most recent correctable or uncorrectable event. This field is not cleared by an acknowledge.
- R8: Writing to offset 0 clears each status bit whose bit in `reg_wdata_i[6:0]` is 1; writing 0x7F clears all seven bits. A write to a capture offset has no effect.
- R9: `irq_o` is high exactly when some status bit `i` is set while mask bit `i` is 0. The mask at offset 1 reads back what was written. The interrupt stays high until the status is acknowledged or masked.
- R10: An event in the same cycle as a write that acknowledges its bit leaves that bit set. If the bit was already set, it also sets the repeated-event bit, and the capture set is not reloaded.
- R11: After reset, the status, mask, syndrome and all capture registers read zero, and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oor_evt_i | input | 1 | Out-of-range access pulse |
| oor_addr_i | input | ADDR_W | Address of the out-of-range access |
| ce_evt_i | input | 1 | Correctable ECC event pulse |
| ue_evt_i | input | 1 | Uncorrectable ECC event pulse |
| ecc_addr_i | input | ADDR_W | Address of the ECC event |
| ecc_data_i | input | DATA_W | Data word of the ECC event |
| ecc_syn_i | input | 8 | Syndrome of the ECC event |
| init_done_i | input | 1 | Memory initialization complete pulse |
| reg_addr_i | input | 4 | Register word offset |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench builds the block with its defaults, ADDR_W = 64 and DATA_W = 64. With these widths every high capture word carries real address and data bits, so a swapped or truncated half shows up at the port. Directed address and data values make the two halves distinct. Repeated events in each class show that the captured values stay frozen. Events that arrive in the same cycle as an acknowledge exercise the rule that the event wins.

// File: rtl/ecclog_pkg.sv
package ecclog_pkg;
  localparam int NUM_SRC = 7;
  localparam int REG_W   = 32;
  localparam int REG_AW  = 4;
  localparam int SYN_W   = 8;
  localparam int SYN_LSB = 16;

  // status bit positions
  localparam int ST_OOR_ONE  = 0;
  localparam int ST_OOR_MANY = 1;
  localparam int ST_CE_ONE   = 2;
  localparam int ST_CE_MANY  = 3;
  localparam int ST_UE_ONE   = 4;
  localparam int ST_UE_MANY  = 5;
  localparam int ST_INIT     = 6;

  // register word offsets
  localparam logic [REG_AW-1:0] OFS_STATUS = 4'd0;
  localparam logic [REG_AW-1:0] OFS_MASK   = 4'd1;
  localparam logic [REG_AW-1:0] OFS_OOR_AL = 4'd2;
  localparam logic [REG_AW-1:0] OFS_OOR_AH = 4'd3;
  localparam logic [REG_AW-1:0] OFS_CE_AL  = 4'd4;
  localparam logic [REG_AW-1:0] OFS_CE_AH  = 4'd5;
  localparam logic [REG_AW-1:0] OFS_CE_DL  = 4'd6;
  localparam logic [REG_AW-1:0] OFS_CE_DH  = 4'd7;
  localparam logic [REG_AW-1:0] OFS_UE_AL  = 4'd8;
  localparam logic [REG_AW-1:0] OFS_UE_AH  = 4'd9;
  localparam logic [REG_AW-1:0] OFS_UE_DL  = 4'd10;
  localparam logic [REG_AW-1:0] OFS_UE_DH  = 4'd11;
endpackage

// File: rtl/ecclog_class_trk.sv
// One error class: first-event bit, repeated-event bit, frozen capture.
module ecclog_class_trk #(
  parameter int CAP_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_i,
  input  logic [CAP_W-1:0] cap_i,
  input  logic             clr_one_i,
  input  logic             clr_many_i,
  output logic             one_o,
  output logic             many_o,
  output logic [CAP_W-1:0] cap_o
);
  logic             one_q, one_d;
  logic             many_q, many_d;
  logic [CAP_W-1:0] cap_q;
  logic             cap_en;

  always_comb begin
    // an event overrides a same-cycle acknowledge
    one_d  = evt_i | (one_q & ~clr_one_i);
    many_d = (evt_i & one_q) | (many_q & ~clr_many_i);
    cap_en = evt_i & ~one_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      one_q  <= 1'b0;
      many_q <= 1'b0;
    end else begin
      one_q  <= one_d;
      many_q <= many_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
    end else if (cap_en) begin
      cap_q <= cap_i;
    end
  end

  assign one_o  = one_q;
  assign many_o = many_q;
  assign cap_o  = cap_q;
endmodule

// File: rtl/ecclog_regs.sv
// Mask, syndrome, init flag, acknowledge decode and read mux.
module ecclog_regs
  import ecclog_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ecc_evt_i,
  input  logic [SYN_W-1:0]           syn_i,
  input  logic                       init_done_i,
  input  logic [NUM_SRC-2:0]         cls_status_i,
  input  logic [ADDR_W-1:0]          oor_cap_i,
  input  logic [ADDR_W+DATA_W-1:0]   ce_cap_i,
  input  logic [ADDR_W+DATA_W-1:0]   ue_cap_i,
  input  logic [REG_AW-1:0]          reg_addr_i,
  input  logic                       reg_we_i,
  input  logic [REG_W-1:0]           reg_wdata_i,
  output logic [NUM_SRC-1:0]         clr_o,
  output logic [NUM_SRC-1:0]         status_o,
  output logic [NUM_SRC-1:0]         mask_o,
  output logic [REG_W-1:0]           reg_rdata_o,
  output logic                       irq_o
);
  localparam int WIDE = 2 * REG_W;

  logic [NUM_SRC-1:0] mask_q;
  logic [SYN_W-1:0]   syn_q;
  logic               init_q, init_d;
  logic               wr_status, wr_mask;
  logic [NUM_SRC-1:0] status;
  logic [WIDE-1:0]    oor_a, ce_a, ce_d, ue_a, ue_d;
  logic               unused_wbits;

  assign wr_status = reg_we_i && (reg_addr_i == OFS_STATUS);
  assign wr_mask   = reg_we_i && (reg_addr_i == OFS_MASK);
  assign clr_o     = wr_status ? reg_wdata_i[NUM_SRC-1:0] : '0;
  assign unused_wbits = ^reg_wdata_i[REG_W-1:NUM_SRC];

  always_comb begin
    init_d = init_done_i | (init_q & ~clr_o[ST_INIT]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q <= 1'b0;
    end else begin
      init_q <= init_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (wr_mask) begin
      mask_q <= reg_wdata_i[NUM_SRC-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syn_q <= '0;
    end else if (ecc_evt_i) begin
      syn_q <= syn_i;
    end
  end

  assign status = {init_q, cls_status_i};

  // zero-extend captures to two register words
  assign oor_a = WIDE'(oor_cap_i);
  assign ce_a  = WIDE'(ce_cap_i[ADDR_W-1:0]);
  assign ce_d  = WIDE'(ce_cap_i[ADDR_W+DATA_W-1:ADDR_W]);
  assign ue_a  = WIDE'(ue_cap_i[ADDR_W-1:0]);
  assign ue_d  = WIDE'(ue_cap_i[ADDR_W+DATA_W-1:ADDR_W]);

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      OFS_STATUS: begin
        reg_rdata_o[NUM_SRC-1:0]             = status;
        reg_rdata_o[SYN_LSB+SYN_W-1:SYN_LSB] = syn_q;
      end
      OFS_MASK:   reg_rdata_o[NUM_SRC-1:0] = mask_q;
      OFS_OOR_AL: reg_rdata_o = oor_a[REG_W-1:0];
      OFS_OOR_AH: reg_rdata_o = oor_a[WIDE-1:REG_W];
      OFS_CE_AL:  reg_rdata_o = ce_a[REG_W-1:0];
      OFS_CE_AH:  reg_rdata_o = ce_a[WIDE-1:REG_W];
      OFS_CE_DL:  reg_rdata_o = ce_d[REG_W-1:0];
      OFS_CE_DH:  reg_rdata_o = ce_d[WIDE-1:REG_W];
      OFS_UE_AL:  reg_rdata_o = ue_a[REG_W-1:0];
      OFS_UE_AH:  reg_rdata_o = ue_a[WIDE-1:REG_W];
      OFS_UE_DL:  reg_rdata_o = ue_d[REG_W-1:0];
      OFS_UE_DH:  reg_rdata_o = ue_d[WIDE-1:REG_W];
      default:    reg_rdata_o = '0;
    endcase
  end

  assign status_o = status;
  assign mask_o   = mask_q;
  assign irq_o    = |(status & ~mask_q);
endmodule

// File: rtl/ecc_err_logger.sv
module ecc_err_logger
  import ecclog_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              oor_evt_i,
  input  logic [ADDR_W-1:0] oor_addr_i,
  input  logic              ce_evt_i,
  input  logic              ue_evt_i,
  input  logic [ADDR_W-1:0] ecc_addr_i,
  input  logic [DATA_W-1:0] ecc_data_i,
  input  logic [7:0]        ecc_syn_i,
  input  logic              init_done_i,
  input  logic [3:0]        reg_addr_i,
  input  logic              reg_we_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              irq_o
);
  localparam int ECC_CAP_W = ADDR_W + DATA_W;
  localparam int NCLS      = 3;

  logic [NUM_SRC-1:0]   clr;
  logic [NUM_SRC-1:0]   status;
  logic [NUM_SRC-1:0]   mask;
  logic [NCLS-1:0]      cls_one, cls_many;
  logic [2*NCLS-1:0]    cls_status;
  logic [ADDR_W-1:0]    oor_cap;
  logic [ECC_CAP_W-1:0] ce_cap, ue_cap;
  logic [ECC_CAP_W-1:0] ecc_cap_in;

  assign ecc_cap_in = {ecc_data_i, ecc_addr_i};

  ecclog_class_trk #(.CAP_W(ADDR_W)) u_oor (
    .clk(clk), .rst_n(rst_n), .evt_i(oor_evt_i), .cap_i(oor_addr_i),
    .clr_one_i(clr[ST_OOR_ONE]), .clr_many_i(clr[ST_OOR_MANY]),
    .one_o(cls_one[0]), .many_o(cls_many[0]), .cap_o(oor_cap)
  );

  ecclog_class_trk #(.CAP_W(ECC_CAP_W)) u_ce (
    .clk(clk), .rst_n(rst_n), .evt_i(ce_evt_i), .cap_i(ecc_cap_in),
    .clr_one_i(clr[ST_CE_ONE]), .clr_many_i(clr[ST_CE_MANY]),
    .one_o(cls_one[1]), .many_o(cls_many[1]), .cap_o(ce_cap)
  );

  ecclog_class_trk #(.CAP_W(ECC_CAP_W)) u_ue (
    .clk(clk), .rst_n(rst_n), .evt_i(ue_evt_i), .cap_i(ecc_cap_in),
    .clr_one_i(clr[ST_UE_ONE]), .clr_many_i(clr[ST_UE_MANY]),
    .one_o(cls_one[2]), .many_o(cls_many[2]), .cap_o(ue_cap)
  );

  // interleave first/repeated bits: class k -> bits 2k, 2k+1
  for (genvar k = 0; k < NCLS; k++) begin : g_pack
    assign cls_status[2*k]   = cls_one[k];
    assign cls_status[2*k+1] = cls_many[k];
  end

  ecclog_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .ecc_evt_i(ce_evt_i | ue_evt_i), .syn_i(ecc_syn_i),
    .init_done_i(init_done_i), .cls_status_i(cls_status),
    .oor_cap_i(oor_cap), .ce_cap_i(ce_cap), .ue_cap_i(ue_cap),
    .reg_addr_i(reg_addr_i), .reg_we_i(reg_we_i), .reg_wdata_i(reg_wdata_i),
    .clr_o(clr), .status_o(status), .mask_o(mask),
    .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
  );
endmodule

// File: rtl/ecclog_chk.sv
module ecclog_chk #(
  parameter int CAP_W = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             oor_evt,
  input logic             ce_evt,
  input logic             ue_evt,
  input logic             init_evt,
  input logic [3:0]       reg_addr,
  input logic             reg_we,
  input logic [31:0]      reg_wdata,
  input logic [6:0]       status,
  input logic [6:0]       mask,
  input logic [CAP_W-1:0] ce_cap,
  input logic [CAP_W-1:0] ue_cap,
  input logic             irq
);
  logic ack_all, any_evt;
  assign ack_all = reg_we && (reg_addr == 4'd0) && (reg_wdata[6:0] == 7'h7F);
  assign any_evt = oor_evt | ce_evt | ue_evt | init_evt;

  p_oor_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    oor_evt |=> status[0]);

  p_ce_many_after_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[3]) |-> $past(status[2]));

  p_ue_repeat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ue_evt && status[4]) |=> status[5]);

  p_init_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    init_evt |=> status[6]);

  p_ce_cap_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    status[2] |=> $stable(ce_cap));

  p_ue_cap_isolated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_evt && !ue_evt) |=> $stable(ue_cap));

  p_ack_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_all && !any_evt) |=> (status == 7'h00));

  p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == 7'h7F) |-> !irq);

  p_event_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ce_evt |=> status[2]);
endmodule

bind ecc_err_logger ecclog_chk #(.CAP_W(ADDR_W + DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .oor_evt(oor_evt_i), .ce_evt(ce_evt_i), .ue_evt(ue_evt_i),
  .init_evt(init_done_i),
  .reg_addr(reg_addr_i), .reg_we(reg_we_i), .reg_wdata(reg_wdata_i),
  .status(status), .mask(mask), .ce_cap(ce_cap), .ue_cap(ue_cap),
  .irq(irq_o)
);

// File: tb/test_ecc_err_logger.sv
`timescale 1ns/1ps
module test_ecc_err_logger;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        oor_evt, ce_evt, ue_evt, init_evt;
  logic [63:0] oor_addr, ecc_addr, ecc_data;
  logic [7:0]  ecc_syn;
  logic [3:0]  reg_addr;
  logic        reg_we;
  logic [31:0] reg_wdata, reg_rdata;
  logic        irq;

  always #4 clk = ~clk;

  ecc_err_logger i_ecc_err_logger (
    .clk(clk), .rst_n(rst_n),
    .oor_evt_i(oor_evt), .oor_addr_i(oor_addr),
    .ce_evt_i(ce_evt), .ue_evt_i(ue_evt),
    .ecc_addr_i(ecc_addr), .ecc_data_i(ecc_data), .ecc_syn_i(ecc_syn),
    .init_done_i(init_evt),
    .reg_addr_i(reg_addr), .reg_we_i(reg_we), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .irq_o(irq)
  );

  // scoreboard queues
  bit          q_kind[$];
  logic [31:0] q_exp[$];
  string       q_tag[$];
  int n_checks = 0;
  int n_fail   = 0;
  bit done = 0;
  bit timed_out = 0;

  task automatic exp_reg(input logic [3:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    reg_addr = a;
    q_kind.push_back(1'b0); q_exp.push_back(e); q_tag.push_back(t);
  endtask

  task automatic exp_irq(input logic e, input string t);
    @(negedge clk);
    q_kind.push_back(1'b1); q_exp.push_back({31'b0, e}); q_tag.push_back(t);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic ecc_pulse(input bit ue, input logic [63:0] a, input logic [63:0] d,
                           input logic [7:0] s);
    @(negedge clk);
    ecc_addr = a; ecc_data = d; ecc_syn = s;
    if (ue) ue_evt = 1'b1; else ce_evt = 1'b1;
    @(negedge clk);
    ce_evt = 1'b0; ue_evt = 1'b0;
  endtask

  task automatic oor_pulse(input logic [63:0] a);
    @(negedge clk);
    oor_addr = a; oor_evt = 1'b1;
    @(negedge clk);
    oor_evt = 1'b0;
  endtask

  // monitor: pops expected items, samples away from the edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q_kind.size() > 0) begin
        bit          k;
        logic [31:0] e, act;
        string       t;
        k = q_kind.pop_front(); e = q_exp.pop_front(); t = q_tag.pop_front();
        act = k ? {31'b0, irq} : reg_rdata;
        n_checks++;
        if (act !== e) begin
          n_fail++;
          $display("FAIL %s actual=%h expected=%h", t, act, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    timed_out = 1;
  end

  initial begin
    rst_n = 1'b0; oor_evt = 0; ce_evt = 0; ue_evt = 0; init_evt = 0;
    oor_addr = '0; ecc_addr = '0; ecc_data = '0; ecc_syn = '0;
    reg_addr = '0; reg_we = 0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    exp_reg(4'd0, 32'h0, "R11 status");
    exp_reg(4'd1, 32'h0, "R11 mask");
    exp_reg(4'd4, 32'h0, "R11 ce addr lo");
    exp_reg(4'd3, 32'h0, "R11 oor addr hi");
    exp_irq(1'b0, "R11 irq");

    // first correctable event
    ecc_pulse(0, 64'h0000_0012_3456_7890, 64'hDEAD_BEEF_0BAD_F00D, 8'h5A);
    exp_reg(4'd0, 32'h005A_0004, "R2 R7 status after first ce");
    exp_irq(1'b1, "R9 irq on ce");
    exp_reg(4'd4, 32'h3456_7890, "R5 ce addr lo");
    exp_reg(4'd5, 32'h0000_0012, "R5 ce addr hi");
    exp_reg(4'd6, 32'h0BAD_F00D, "R5 ce data lo");
    exp_reg(4'd7, 32'hDEAD_BEEF, "R5 ce data hi");

    // repeated correctable event
    ecc_pulse(0, 64'h0000_0000_0000_0100, 64'h1111_2222_3333_4444, 8'h33);
    exp_reg(4'd0, 32'h0033_000C, "R2 R7 status after second ce");
    exp_reg(4'd4, 32'h3456_7890, "R5 ce addr lo frozen");
    exp_reg(4'd7, 32'hDEAD_BEEF, "R5 ce data hi frozen");

    // uncorrectable events
    ecc_pulse(1, 64'h0000_00AB_CDEF_0040, 64'h5555_6666_7777_8888, 8'h81);
    exp_reg(4'd0, 32'h0081_001C, "R3 status after first ue");
    exp_reg(4'd8, 32'hCDEF_0040, "R6 ue addr lo");
    exp_reg(4'd9, 32'h0000_00AB, "R6 ue addr hi");
    exp_reg(4'd10, 32'h7777_8888, "R6 ue data lo");
    exp_reg(4'd11, 32'h5555_6666, "R6 ue data hi");
    exp_reg(4'd4, 32'h3456_7890, "R6 ce set untouched by ue");
    ecc_pulse(1, 64'h0000_0000_0000_0100, 64'h1111_2222_3333_4444, 8'h81);
    exp_reg(4'd0, 32'h0081_003C, "R3 status after second ue");
    exp_reg(4'd8, 32'hCDEF_0040, "R5 ue addr lo frozen");

    // out-of-range events
    oor_pulse(64'h0000_0001_0000_0010);
    exp_reg(4'd0, 32'h0081_003D, "R1 status after first oor");
    exp_reg(4'd2, 32'h0000_0010, "R1 oor addr lo");
    exp_reg(4'd3, 32'h0000_0001, "R1 oor addr hi");
    oor_pulse(64'h0000_0000_0000_2000);
    exp_reg(4'd0, 32'h0081_003F, "R1 status after second oor");
    exp_reg(4'd2, 32'h0000_0010, "R1 oor addr frozen");

    // init done
    @(negedge clk); init_evt = 1'b1;
    @(negedge clk); init_evt = 1'b0;
    exp_reg(4'd0, 32'h0081_007F, "R4 init bit");

    // mask
    wr(4'd1, 32'h0000_007F);
    exp_reg(4'd1, 32'h0000_007F, "R9 mask readback");
    exp_irq(1'b0, "R9 all masked");
    exp_reg(4'd0, 32'h0081_007F, "R9 masking keeps status");
    wr(4'd1, 32'h0000_003F);
    exp_irq(1'b1, "R9 init unmasked");
    wr(4'd1, 32'h0000_0000);

    // acknowledge
    wr(4'd0, 32'h0000_0003);
    exp_reg(4'd0, 32'h0081_007C, "R8 partial ack");
    wr(4'd2, 32'hFFFF_FFFF);
    exp_reg(4'd2, 32'h0000_0010, "R8 capture write ignored");
    exp_irq(1'b1, "R9 irq held before ack");
    wr(4'd0, 32'h0000_007F);
    exp_reg(4'd0, 32'h0081_0000, "R8 R7 ack all keeps syndrome");
    exp_irq(1'b0, "R9 irq low after ack");

    // event in the same cycle as acknowledge, bit clear before
    @(negedge clk);
    ecc_addr = 64'h0000_0000_0000_0800; ecc_data = 64'h0; ecc_syn = 8'h0E;
    ce_evt = 1'b1; reg_we = 1'b1; reg_addr = 4'd0; reg_wdata = 32'h7F;
    @(negedge clk);
    ce_evt = 1'b0; reg_we = 1'b0;
    exp_reg(4'd0, 32'h000E_0004, "R10 event wins over ack");
    exp_reg(4'd4, 32'h0000_0800, "R5 recapture after ack");

    // same-cycle event and ack while first bit is set
    @(negedge clk);
    ecc_addr = 64'h0000_0000_0000_0100; ecc_syn = 8'h33;
    ce_evt = 1'b1; reg_we = 1'b1; reg_addr = 4'd0; reg_wdata = 32'h04;
    @(negedge clk);
    ce_evt = 1'b0; reg_we = 1'b0;
    exp_reg(4'd0, 32'h0033_000C, "R10 set bit survives ack, repeat set");
    exp_reg(4'd4, 32'h0000_0800, "R10 no reload");

    repeat (4) @(negedge clk);
    done = 1;
  end

  initial begin
    wait (done || timed_out);
    if (timed_out) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule